// File: doc/BRIEF.md
# Pin connectivity pattern generator

This block drives every pin of a bank with a known, repeating waveform so that a freshly assembled programmable logic device can be checked pin by pin after soldering. It runs from one crystal clock (24.576 MHz on the board) and derives every waveform by counting that clock. A single mode input selects between two patterns.

In frequency mode, each pin carries a divided copy of the clock, taken from one bit of a free-running binary counter. Pin i takes bit (i mod DIV_STAGES), so pin 0 toggles every clock and each following pin toggles half as often. An oscilloscope probe then shows a different rate on neighbouring pins. In duty mode, every pin repeats with a period of 3·DUTY_STEP clocks (9 clocks, about 2.73 MHz by default). The pin's index modulo 4 picks its high time: 0, one third, two thirds or the whole period. A voltmeter behind an RC filter then reads one of four distinct DC levels, and a short between neighbours shows up as a wrong reading.

Top module: `pin_probe_pattern_gen`

## Requirements
- R1: A synchronous active-high reset on `rst_i` drives every bit of `pins_o` to 0 at the next rising clock edge and clears both pattern counters. In duty mode, the first edge after reset is released produces the phase-0 pattern.
- R2: With `mode_i` = 0 (frequency mode), pin i is high for 2^k clocks and low for 2^k clocks, where k = i mod DIV_STAGES.
- R3: In frequency mode, any two adjacent pins toggle at different rates.
- R4: With `mode_i` = 1 (duty mode), every toggling pin repeats with a period of 3·DUTY_STEP clocks.
- R5: In duty mode, the code of pin i is i mod 4. The pin is high for code·DUTY_STEP clocks of each period: code 0 is constantly low and code 3 is constantly high. Adjacent pins therefore have different high counts in any window of one period.
- R6: When `mode_i` changes to 1, both counters restart. The outputs after the second rising edge show phase 0 (pin high if its code is non-zero). After 3, 6 and 9 further edges they show phases 3, 6 and 0, where a pin is high if phase < code·DUTY_STEP.
- R7: When `mode_i` changes to 0, the outputs after the second rising edge are all 0. After the third edge, only pins with i mod DIV_STAGES = 0 are high. After the fourth edge, only pins with i mod DIV_STAGES = 1 are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference crystal clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Pattern select: 0 = divided clocks, 1 = duty-cycle codes |
| pins_o | output | NUM_PINS | Registered test waveforms, one per device pin |

## Verification
The bench builds the block with NUM_PINS = 12, DIV_STAGES = 6 and DUTY_STEP = 3. The slowest divider then has a period of 64 clocks, so every divided clock completes full high and low phases within a short window. Twelve pins wrap around the divider chain at pin 6 and cover each duty code three times. This brings into reach the stage wrap between pins 5 and 6, constant-low and constant-high codes on non-first pins, and the restart timing after a mode switch in both directions. The 19-stage default keeps the same structure, but its top stage would need far more cycles than a short run allows.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
   typedef enum logic {
      PAT_FREQ = 1'b0,
      PAT_DUTY = 1'b1
   } pat_mode_e;

   localparam int unsigned NUM_CODES = 4;

   typedef logic [1:0] duty_code_t;

   // Duty code carried by a pin: neighbours always differ.
   function automatic duty_code_t code_of_pin(input int unsigned idx);
      return duty_code_t'(idx % NUM_CODES);
   endfunction
endpackage

// File: rtl/ppg_div_counter.sv
module ppg_div_counter #(
   parameter int unsigned WIDTH = 19
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             restart_i,
   output logic [WIDTH-1:0] cnt_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i) cnt_o <= '0;
      else                    cnt_o <= cnt_o + 1'b1;
   end

   // R2: the divider chain advances by exactly one each free-running cycle
   assert_div_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !restart_i |=> cnt_o == WIDTH'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/ppg_phase_counter.sv
module ppg_phase_counter #(
   parameter int unsigned PERIOD = 9,
   localparam int unsigned PW    = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          restart_i,
   output logic [PW-1:0] phase_o
);
   localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i)  phase_o <= '0;
      else if (phase_o == LAST) phase_o <= '0;
      else                      phase_o <= phase_o + 1'b1;
   end

   // R4: phase never leaves the period
   assert_phase_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      phase_o <= LAST);

   // R4: the last phase is followed by phase zero
   assert_phase_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_o == LAST && !restart_i) |=> phase_o == '0);
endmodule

// File: rtl/ppg_pin_lane.sv
module ppg_pin_lane
   import ppg_pkg::*;
#(
   parameter int unsigned PIN_IDX    = 0,
   parameter int unsigned DIV_STAGES = 19,
   parameter int unsigned DUTY_STEP  = 3,
   parameter int unsigned PW         = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  pat_mode_e             mode_i,
   input  logic [DIV_STAGES-1:0] div_cnt_i,
   input  logic [PW-1:0]         phase_i,
   output logic                  pin_o
);
   localparam int unsigned STAGE    = PIN_IDX % DIV_STAGES;
   localparam duty_code_t  CODE     = code_of_pin(PIN_IDX);
   localparam int unsigned HIGH_LEN = int'(CODE) * DUTY_STEP;

   logic duty_lvl;

   generate
      if (CODE == 2'd0) begin : g_code_low
         assign duty_lvl = 1'b0;
         // R5: code 0 stays low in duty mode
         assert_code_low_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_i == PAT_DUTY) |=> !pin_o);
      end else if (CODE == 2'd3) begin : g_code_high
         assign duty_lvl = 1'b1;
         // R5: code 3 stays high in duty mode
         assert_code_high_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_i == PAT_DUTY) |=> pin_o);
      end else begin : g_code_mid
         localparam logic [PW-1:0] HIGH_CMP = PW'(HIGH_LEN);
         assign duty_lvl = (phase_i < HIGH_CMP);
         // R5: partial codes start each period high and end it low
         assert_code_start_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_i == PAT_DUTY && phase_i == '0) |=> pin_o);
         assert_code_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode_i == PAT_DUTY && phase_i == PW'(3 * DUTY_STEP - 1)) |=> !pin_o);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)                     pin_o <= 1'b0;
      else if (mode_i == PAT_DUTY)   pin_o <= duty_lvl;
      else                           pin_o <= div_cnt_i[STAGE];
   end
endmodule

// File: rtl/pin_probe_pattern_gen.sv
module pin_probe_pattern_gen
   import ppg_pkg::*;
#(
   parameter int unsigned NUM_PINS   = 40,
   parameter int unsigned DIV_STAGES = 19,
   parameter int unsigned DUTY_STEP  = 3
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                mode_i,
   output logic [NUM_PINS-1:0] pins_o
);
   localparam int unsigned DUTY_PERIOD = NUM_CODES - 1 == 3 ? 3 * DUTY_STEP : 0;
   localparam int unsigned PW          = (DUTY_PERIOD > 2) ? $clog2(DUTY_PERIOD) : 1;

   generate
      if (NUM_PINS < 2) begin : g_bad_pins
         $error("pin_probe_pattern_gen: NUM_PINS must be at least 2");
      end
      if (DIV_STAGES < 2) begin : g_bad_stages
         $error("pin_probe_pattern_gen: DIV_STAGES must be at least 2");
      end
      if (DUTY_STEP < 1) begin : g_bad_step
         $error("pin_probe_pattern_gen: DUTY_STEP must be at least 1");
      end
   endgenerate

   pat_mode_e             mode_q;
   logic                  restart;
   logic [DIV_STAGES-1:0] div_cnt;
   logic [PW-1:0]         phase;

   // Mode is sampled every cycle, also during reset, so release is clean.
   always_ff @(posedge clk_i) mode_q <= pat_mode_e'(mode_i);

   assign restart = (pat_mode_e'(mode_i) != mode_q);

   ppg_div_counter #(.WIDTH(DIV_STAGES)) u_div (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (restart),
      .cnt_o     (div_cnt)
   );

   ppg_phase_counter #(.PERIOD(DUTY_PERIOD)) u_phase (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (restart),
      .phase_o   (phase)
   );

   generate
      for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_lane
         ppg_pin_lane #(
            .PIN_IDX    (gi),
            .DIV_STAGES (DIV_STAGES),
            .DUTY_STEP  (DUTY_STEP),
            .PW         (PW)
         ) u_lane (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .mode_i    (mode_q),
            .div_cnt_i (div_cnt),
            .phase_i   (phase),
            .pin_o     (pins_o[gi])
         );
      end
   endgenerate

   // R1: reset clears every output at the next edge
   assert_reset_clear_R1: assert property (@(posedge clk_i)
      rst_i |=> (pins_o == '0 && div_cnt == '0 && phase == '0));

   // R6: a mode change restarts both counters on the following cycle
   assert_mode_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      restart |=> (div_cnt == '0 && phase == '0));
endmodule

// File: tb/pin_probe_pattern_gen_test.sv
module pin_probe_pattern_gen_test;
   localparam int NP   = 12;
   localparam int NS   = 6;
   localparam int STEP = 3;
   localparam int PER  = 3 * STEP;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode = 1'b0;
   logic [NP-1:0] pins;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   pin_probe_pattern_gen #(.NUM_PINS(NP), .DIV_STAGES(NS), .DUTY_STEP(STEP)) uut (
      .clk_i  (clk),
      .rst_i  (rst),
      .mode_i (mode),
      .pins_o (pins)
   );

   // {mode, pin, expected high count (level if constant), expected period (0 = constant)}
   localparam int NV = 12;
   localparam int VEC[NV][4] = '{
      '{0, 0,  1,  2}, '{0, 1,  2,  4}, '{0, 2,  4,  8},
      '{0, 5, 32, 64}, '{0, 6,  1,  2}, '{0, 11, 32, 64},
      '{1, 0,  0,  0}, '{1, 1,  3,  9}, '{1, 2,  6,  9},
      '{1, 3,  1,  0}, '{1, 4,  0,  0}, '{1, 10, 6,  9}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Expected duty-mode vector at a given phase
   function automatic logic [NP-1:0] duty_vec(input int ph);
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = (ph < (i % 4) * STEP);
      return v;
   endfunction

   // Expected frequency-mode vector for a given counter value
   function automatic logic [NP-1:0] freq_vec(input int cnt);
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = cnt[i % NS];
      return v;
   endfunction

   task automatic measure(input int pin, output int high, output int period);
      int r1 = -1, f1 = -1, r2 = -1;
      logic prev, cur;
      prev = pins[pin];
      cur  = prev;
      for (int t = 1; t <= 200; t++) begin
         @(negedge clk);
         cur = pins[pin];
         if (!prev && cur) begin
            if (r1 < 0) r1 = t;
            else if (f1 >= 0 && r2 < 0) r2 = t;
         end
         if (prev && !cur && r1 >= 0 && f1 < 0) f1 = t;
         prev = cur;
      end
      if (r2 < 0) begin
         period = 0;
         high   = int'(cur);
      end else begin
         period = r2 - r1;
         high   = f1 - r1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int hi, pd;
      int tog[NP];
      logic [NP-1:0] prev;

      // Reset state (R1)
      tick(5);
      check("R1", "outputs during reset", int'(pins), 0);
      rst = 1'b0;
      tick(3);

      // Table walk: R2 for frequency entries, R4/R5 for duty entries
      for (int v = 0; v < NV; v++) begin
         if (mode != VEC[v][0][0]) begin
            mode = VEC[v][0][0];
            tick(20);
         end
         measure(VEC[v][1], hi, pd);
         if (VEC[v][0] == 0) begin
            check("R2", $sformatf("pin %0d high time", VEC[v][1]), hi, VEC[v][2]);
            check("R2", $sformatf("pin %0d period", VEC[v][1]), pd, VEC[v][3]);
         end else begin
            check("R5", $sformatf("pin %0d high time", VEC[v][1]), hi, VEC[v][2]);
            check("R4", $sformatf("pin %0d period", VEC[v][1]), pd, VEC[v][3]);
         end
      end

      // Duty mode: high count over one period differs between neighbours (R5)
      for (int i = 0; i < NP; i++) tog[i] = 0;
      for (int t = 0; t < PER; t++) begin
         @(negedge clk);
         for (int i = 0; i < NP; i++) tog[i] += int'(pins[i]);
      end
      for (int i = 0; i < NP; i++)
         check("R5", $sformatf("pin %0d high count per period", i), tog[i], (i % 4) * STEP);
      for (int i = 0; i < NP - 1; i++)
         check("R5", $sformatf("pins %0d/%0d high counts differ", i, i + 1),
               int'(tog[i] != tog[i + 1]), 1);

      // Switch to frequency mode and check restart (R7)
      mode = 1'b0;
      tick(2);
      check("R7", "outputs two edges after switch", int'(pins), 0);
      tick(1);
      check("R7", "outputs three edges after switch", int'(pins), int'(freq_vec(1)));
      tick(1);
      check("R7", "outputs four edges after switch", int'(pins), int'(freq_vec(2)));

      // Neighbour toggle rates differ in frequency mode (R3)
      for (int i = 0; i < NP; i++) tog[i] = 0;
      prev = pins;
      for (int t = 0; t < 128; t++) begin
         @(negedge clk);
         for (int i = 0; i < NP; i++) if (pins[i] != prev[i]) tog[i]++;
         prev = pins;
      end
      for (int i = 0; i < NP - 1; i++)
         check("R3", $sformatf("pins %0d/%0d toggle rates differ (%0d vs %0d)",
               i, i + 1, tog[i], tog[i + 1]), int'(tog[i] != tog[i + 1]), 1);

      // Switch to duty mode and check restart phases (R6)
      mode = 1'b1;
      tick(2);
      check("R6", "phase 0 after switch", int'(pins), int'(duty_vec(0)));
      tick(3);
      check("R6", "phase 3 after switch", int'(pins), int'(duty_vec(3)));
      tick(3);
      check("R6", "phase 6 after switch", int'(pins), int'(duty_vec(6)));
      tick(3);
      check("R6", "phase 0 again", int'(pins), int'(duty_vec(0)));

      // Mid-run reset in duty mode (R1)
      tick(4);
      rst = 1'b1;
      tick(1);
      check("R1", "outputs after mid-run reset", int'(pins), 0);
      tick(2);
      check("R1", "outputs held in reset", int'(pins), 0);
      rst = 1'b0;
      tick(1);
      check("R1", "phase 0 first edge after reset", int'(pins), int'(duty_vec(0)));
      tick(1);
      check("R1", "phase 1 second edge after reset", int'(pins), int'(duty_vec(1)));

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule